// File: doc/BRIEF.md
# I2C Target with Pointer-Addressed Byte Memory Access

This block is an I2C target that lets a bus host read and write a byte-wide memory that sits beside it. The block holds a 16-bit pointer. A write-direction transaction loads this pointer from two bytes sent after the target address, high byte first. Any further bytes in that transaction are stored at successive locations. A read-direction transaction returns bytes starting at the pointer. It returns bytes for as long as the host acknowledges them. The pointer advances by one for each byte moved and wraps at the top of the 16-bit space.

The bus lines are sampled on the system clock. Each line passes through a two-flop synchronizer and then a stable-count filter, so short spikes never reach START, STOP or bit detection. A transaction may consist of only the two pointer bytes, which leaves the pointer set for a later read. A repeated START can join the pointer load and the read into one transaction. The memory port is synchronous. The address always shows the pointer, a write is a one-cycle enable pulse, and read data is expected one clock after the address. The system clock must run at least 16 times faster than SCL.

Top module: `i2cmem_target`

## Requirements
- R1: After reset the block does not pull SDA low, mem_we_o is low and mem_addr_o is 0x0000.
- R2: An address byte whose upper seven bits equal DEV_ADDR is acknowledged. Any other address byte gets no acknowledge, and the target then leaves SDA released and writes nothing until the next START.
- R3: In a write-direction transaction the two bytes after the address byte form the pointer, high byte first, and each is acknowledged. A STOP right after them changes only the pointer (visible on mem_addr_o) and writes nothing.
- R4: Each further byte of a write-direction transaction is acknowledged and written once (one-cycle mem_we_o pulse) at the current pointer. Successive bytes go to successive addresses.
- R5: A read-direction transaction with no pointer bytes returns data from the pointer left by earlier transactions.
- R6: A header with the address (bit 0 = 0) and two pointer bytes, followed by a repeated START and the address with bit 0 = 1, returns data from the newly loaded pointer.
- R7: The pointer advances by one after each byte written or sent and wraps from 0xFFFF to 0x0000.
- R8: In a read, the target keeps sending bytes while the host acknowledges each one. A host NACK (SDA high in the ninth clock) ends the data phase, and SDA stays released.
- R9: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks after synchronization has no effect on the received data or on condition detection.
- R10: The target pulls SDA low through the ninth clock of each byte it receives and acknowledges. It releases SDA after the following SCL falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL bus line |
| sda_i | input | 1 | Sampled SDA bus line |
| sda_low_o | output | 1 | High pulls SDA low (open-drain enable) |
| mem_addr_o | output | 16 | Memory address, equal to the pointer |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | One-cycle memory write enable |
| mem_rdata_i | input | 8 | Memory read data, one clock after address |

## Verification
The hardest situations to reach from the ports are spikes that arrive in the worst place. Such a spike is an SCL pulse inside the low phase of a data bit, or an SDA dip while SCL is high that would look like a START if it got through. The bench drives a write with two-clock spikes of both kinds on every bit. It then reads the data back with a combined read, so a spike that got through would show up as a wrong or missing byte. The pointer wrap is reached by loading 0xFFFF and writing across the boundary. A read that then starts at 0xFFFE covers the wrap in the sending direction as well.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;
    localparam int PTR_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RACK,
        ST_TX,
        ST_TACK,
        ST_SKIP
    } tgt_state_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_HI,
        PH_LO,
        PH_DATA
    } rx_phase_e;
endpackage

// File: rtl/i2cmem_filter.sv
module i2cmem_filter #(
    parameter int   FILT_LEN  = 3,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             out;
        logic [CNT_W-1:0] cnt;
    } filt_t;

    filt_t f_d, f_q;

    always_comb begin
        f_d    = f_q;
        f_d.s1 = line_i;
        f_d.s2 = f_q.s1;
        if (f_q.s2 == f_q.out) begin
            f_d.cnt = '0;
        end else if (f_q.cnt == CNT_W'(FILT_LEN - 1)) begin
            f_d.out = f_q.s2;
            f_d.cnt = '0;
        end else begin
            f_d.cnt = f_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{s1: RESET_VAL, s2: RESET_VAL, out: RESET_VAL, cnt: '0};
        end else begin
            f_q <= f_d;
        end
    end

    assign line_o = f_q.out;

    // R9
    filter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.out != $past(f_q.out)) |-> ($past(f_q.cnt) == CNT_W'(FILT_LEN - 1)));
endmodule

// File: rtl/i2cmem_events.sv
module i2cmem_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t p_d, p_q;

    always_comb begin
        p_d.scl = scl_f;
        p_d.sda = sda_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '{scl: 1'b1, sda: 1'b1};
        else        p_q <= p_d;
    end

    assign scl_rise = !p_q.scl && scl_f;
    assign scl_fall = p_q.scl && !scl_f;
    assign start_o  = p_q.scl && scl_f && p_q.sda && !sda_f;
    assign stop_o   = p_q.scl && scl_f && !p_q.sda && sda_f;
endmodule

// File: rtl/i2cmem_target.sv
module i2cmem_target
    import i2cmem_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h42,
    parameter int         FILT_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_low_o,
    output logic [PTR_W-1:0]  mem_addr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    input  logic [BYTE_W-1:0] mem_rdata_i
);
    localparam int BIT_W = $clog2(BYTE_W);

    logic [1:0] raw_lines, filt_lines;
    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        i2cmem_filter #(.FILT_LEN(FILT_LEN), .RESET_VAL(1'b1)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (filt_lines[g])
        );
    end

    logic scl_f, sda_f;
    assign scl_f = filt_lines[1];
    assign sda_f = filt_lines[0];

    logic scl_rise, scl_fall, start_evt, stop_evt;

    i2cmem_events u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_f),
        .sda_f    (sda_f),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_o  (start_evt),
        .stop_o   (stop_evt)
    );

    typedef struct packed {
        tgt_state_e        st;
        rx_phase_e         ph;
        logic [BIT_W-1:0]  bitc;
        logic              full;
        logic [BYTE_W-1:0] sh;
        logic              rw;
        logic              hack;
        logic              oe;
        logic [BYTE_W-1:0] hi;
        logic [PTR_W-1:0]  ptr;
        logic              inc;
        logic              we;
        logic [BYTE_W-1:0] wd;
    } tgt_t;

    tgt_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.we  = 1'b0;
        r_d.inc = 1'b0;
        if (r_q.inc) r_d.ptr = r_q.ptr + PTR_W'(1);

        if (stop_evt) begin
            r_d.st = ST_IDLE;
            r_d.oe = 1'b0;
        end else if (start_evt) begin
            r_d.st   = ST_RX;
            r_d.ph   = PH_DEV;
            r_d.bitc = '0;
            r_d.full = 1'b0;
            r_d.oe   = 1'b0;
        end else begin
            case (r_q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        r_d.sh   = {r_q.sh[BYTE_W-2:0], sda_f};
                        r_d.bitc = r_q.bitc + BIT_W'(1);
                        if (r_q.bitc == BIT_W'(BYTE_W - 1)) r_d.full = 1'b1;
                    end else if (scl_fall && r_q.full) begin
                        r_d.full = 1'b0;
                        r_d.bitc = '0;
                        r_d.st   = ST_RACK;
                        r_d.oe   = 1'b1;
                        case (r_q.ph)
                            PH_DEV: begin
                                if (r_q.sh[BYTE_W-1:1] == DEV_ADDR) begin
                                    r_d.rw = r_q.sh[0];
                                end else begin
                                    r_d.st = ST_SKIP;
                                    r_d.oe = 1'b0;
                                end
                            end
                            PH_HI:   r_d.hi  = r_q.sh;
                            PH_LO:   r_d.ptr = {r_q.hi, r_q.sh};
                            default: begin
                                r_d.we  = 1'b1;
                                r_d.wd  = r_q.sh;
                                r_d.inc = 1'b1;
                            end
                        endcase
                    end
                end
                ST_RACK: begin
                    if (scl_fall) begin
                        r_d.oe   = 1'b0;
                        r_d.bitc = '0;
                        if (r_q.ph == PH_DEV && r_q.rw) begin
                            r_d.st = ST_TX;
                            r_d.sh = mem_rdata_i;
                            r_d.oe = !mem_rdata_i[BYTE_W-1];
                        end else begin
                            r_d.st = ST_RX;
                            case (r_q.ph)
                                PH_DEV:  r_d.ph = PH_HI;
                                PH_HI:   r_d.ph = PH_LO;
                                default: r_d.ph = PH_DATA;
                            endcase
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (r_q.bitc == BIT_W'(BYTE_W - 1)) begin
                            r_d.st  = ST_TACK;
                            r_d.oe  = 1'b0;
                            r_d.inc = 1'b1;
                        end else begin
                            r_d.bitc = r_q.bitc + BIT_W'(1);
                            r_d.sh   = {r_q.sh[BYTE_W-2:0], 1'b0};
                            r_d.oe   = !r_q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_TACK: begin
                    if (scl_rise) begin
                        r_d.hack = !sda_f;
                    end else if (scl_fall) begin
                        if (r_q.hack) begin
                            r_d.st   = ST_TX;
                            r_d.bitc = '0;
                            r_d.sh   = mem_rdata_i;
                            r_d.oe   = !mem_rdata_i[BYTE_W-1];
                        end else begin
                            r_d.st = ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, ph: PH_DEV, bitc: '0, full: 1'b0, sh: '0, rw: 1'b0,
                     hack: 1'b0, oe: 1'b0, hi: '0, ptr: '0, inc: 1'b0, we: 1'b0, wd: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_low_o   = r_q.oe;
    assign mem_addr_o  = r_q.ptr;
    assign mem_wdata_o = r_q.wd;
    assign mem_we_o    = r_q.we;

    // R2
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SKIP) |-> (!sda_low_o && !mem_we_o));

    // R4
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> !mem_we_o);

    // R7
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.inc |=> (mem_addr_o == $past(mem_addr_o) + PTR_W'(1)));

    // R10
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RACK && scl_fall && !(r_q.ph == PH_DEV && r_q.rw)) |=> !sda_low_o);

    // R8
    drive_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_low_o |-> (r_q.st == ST_RACK || r_q.st == ST_TX));
endmodule

// File: tb/sim_i2cmem_target.sv
module sim_i2cmem_target;
    localparam int Q = 10;
    localparam logic [6:0] DEV = 7'h42;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl_h = 1'b1, sda_h_low = 1'b0, scl_gl = 1'b0, sda_gl = 1'b0;
    logic sda_low_dut, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    wire scl_line = scl_h ^ scl_gl;
    wire sda_line = ~(sda_h_low | sda_low_dut | sda_gl);

    i2cmem_target #(.DEV_ADDR(DEV), .FILT_LEN(3)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .sda_low_o(sda_low_dut), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_we_o(mem_we), .mem_rdata_i(mem_rdata));

    int nchk = 0, nerr = 0;
    bit done = 1'b0;
    logic [7:0]  mem [logic [15:0]];
    logic [23:0] exp_q [$];

    function automatic logic [7:0] init_val(logic [15:0] a);
        return (a[7:0] * 8'd7) + a[15:8] + 8'd3;
    endfunction

    function automatic logic [7:0] model_rd(logic [15:0] a);
        return mem.exists(a) ? mem[a] : init_val(a);
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] = mem_wdata;
        mem_rdata <= model_rd(mem_addr);
    end

    // monitor: pops expected writes as the design produces them
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2/R3 unexpected write", {8'h0, mem_addr, mem_wdata}, 32'h0);
            end else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                chk({mem_addr, mem_wdata} == e, "R4/R7 write addr+data",
                    {8'h0, mem_addr, mem_wdata}, {8'h0, e});
            end
        end
    end

    task automatic w(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_c();
        sda_h_low = 1'b1; w(Q); scl_h = 1'b0; w(Q);
    endtask

    task automatic rstart_c();
        sda_h_low = 1'b0; w(Q); scl_h = 1'b1; w(Q);
        sda_h_low = 1'b1; w(Q); scl_h = 1'b0; w(Q);
    endtask

    task automatic stop_c();
        sda_h_low = 1'b1; w(Q); scl_h = 1'b1; w(Q); sda_h_low = 1'b0; w(2 * Q);
    endtask

    task automatic wbit(logic b, bit glitch);
        sda_h_low = !b;
        if (glitch) begin
            w(Q / 2); scl_gl = 1'b1; w(2); scl_gl = 1'b0; w(Q - Q / 2 - 2);
        end else w(Q);
        scl_h = 1'b1;
        if (glitch && b) begin
            w(Q / 2); sda_gl = 1'b1; w(2); sda_gl = 1'b0; w(2 * Q - Q / 2 - 2);
        end else w(2 * Q);
        scl_h = 1'b0; w(Q);
    endtask

    task automatic rbit(output logic b);
        sda_h_low = 1'b0; w(Q); scl_h = 1'b1; w(Q);
        b = sda_line; w(Q); scl_h = 1'b0; w(Q);
    endtask

    task automatic send_byte(logic [7:0] d, bit exp_ack, bit glitch, bit relchk, string req);
        logic a;
        for (int i = 7; i >= 0; i--) wbit(d[i], glitch);
        rbit(a);
        chk(a == !exp_ack, req, {31'h0, a}, {31'h0, !exp_ack});
        if (relchk) chk(sda_line == 1'b1, "R10 ack released after ninth clock", {31'h0, sda_line}, 32'h1);
    endtask

    task automatic recv_byte(logic [7:0] exp, bit more, string req);
        logic [7:0] d;
        for (int i = 7; i >= 0; i--) rbit(d[i]);
        chk(d == exp, req, {24'h0, d}, {24'h0, exp});
        wbit(!more, 1'b0);
    endtask

    task automatic header(logic [15:0] p);
        start_c();
        send_byte({DEV, 1'b0}, 1'b1, 1'b0, 1'b1, "R2 address ack");
        send_byte(p[15:8], 1'b1, 1'b0, 1'b1, "R3 pointer high ack");
        send_byte(p[7:0], 1'b1, 1'b0, 1'b1, "R3 pointer low ack");
    endtask

    initial begin
        w(5);
        rst_n = 1'b1;
        w(10);
        chk(sda_line == 1'b1, "R1 sda released", {31'h0, sda_line}, 32'h1);
        chk(mem_we == 1'b0, "R1 no write", {31'h0, mem_we}, 32'h0);
        chk(mem_addr == 16'h0, "R1 pointer zero", {16'h0, mem_addr}, 32'h0);

        // R4: three data bytes at 0x1234
        exp_q.push_back({16'h1234, 8'hA1});
        exp_q.push_back({16'h1235, 8'hB2});
        exp_q.push_back({16'h1236, 8'hC3});
        header(16'h1234);
        send_byte(8'hA1, 1'b1, 1'b0, 1'b1, "R4 data ack");
        send_byte(8'hB2, 1'b1, 1'b0, 1'b1, "R4 data ack");
        send_byte(8'hC3, 1'b1, 1'b0, 1'b1, "R4 data ack");
        stop_c();

        // R3: pointer-only transaction
        header(16'h2000);
        stop_c();
        chk(mem_addr == 16'h2000, "R3 pointer loaded", {16'h0, mem_addr}, 32'h2000);

        // R5 + R8: read with no pointer phase, host NACKs second byte
        start_c();
        send_byte({DEV, 1'b1}, 1'b1, 1'b0, 1'b0, "R2 read address ack");
        recv_byte(model_rd(16'h2000), 1'b1, "R5 read from stored pointer");
        recv_byte(model_rd(16'h2001), 1'b0, "R5 second byte");
        w(2 * Q);
        chk(sda_line == 1'b1, "R8 sda released after host nack", {31'h0, sda_line}, 32'h1);
        stop_c();

        // R6: combined read of earlier writes
        header(16'h1235);
        rstart_c();
        send_byte({DEV, 1'b1}, 1'b1, 1'b0, 1'b0, "R6 read address ack");
        recv_byte(8'hB2, 1'b1, "R6 combined read byte 0");
        recv_byte(8'hC3, 1'b0, "R6 combined read byte 1");
        stop_c();

        // R7: wrap on write, then on read
        exp_q.push_back({16'hFFFF, 8'h5A});
        exp_q.push_back({16'h0000, 8'h6B});
        header(16'hFFFF);
        send_byte(8'h5A, 1'b1, 1'b0, 1'b1, "R7 data ack");
        send_byte(8'h6B, 1'b1, 1'b0, 1'b1, "R7 data ack");
        stop_c();
        header(16'hFFFE);
        rstart_c();
        send_byte({DEV, 1'b1}, 1'b1, 1'b0, 1'b0, "R7 read address ack");
        recv_byte(init_val(16'hFFFE), 1'b1, "R7 read 0xFFFE");
        recv_byte(8'h5A, 1'b1, "R7 read 0xFFFF");
        recv_byte(8'h6B, 1'b0, "R7 read wrapped 0x0000");
        stop_c();

        // R2: wrong address is ignored, pointer and memory untouched
        start_c();
        send_byte({7'h17, 1'b0}, 1'b0, 1'b0, 1'b0, "R2 wrong address nack");
        send_byte(8'h05, 1'b0, 1'b0, 1'b0, "R2 ignored byte nack");
        send_byte(8'h00, 1'b0, 1'b0, 1'b0, "R2 ignored byte nack");
        send_byte(8'hEE, 1'b0, 1'b0, 1'b0, "R2 ignored byte nack");
        stop_c();
        chk(mem_addr == 16'h0001, "R2 pointer unchanged", {16'h0, mem_addr}, 32'h0001);
        start_c();
        send_byte({DEV, 1'b1}, 1'b1, 1'b0, 1'b0, "R5 read address ack");
        recv_byte(init_val(16'h0001), 1'b0, "R5 resume at 0x0001");
        stop_c();

        // R9: spikes on both lines during a write
        exp_q.push_back({16'h0300, 8'hB6});
        exp_q.push_back({16'h0301, 8'h3D});
        header(16'h0300);
        send_byte(8'hB6, 1'b1, 1'b1, 1'b1, "R9 ack with spikes");
        send_byte(8'h3D, 1'b1, 1'b1, 1'b1, "R9 ack with spikes");
        stop_c();
        header(16'h0300);
        rstart_c();
        send_byte({DEV, 1'b1}, 1'b1, 1'b0, 1'b0, "R9 read address ack");
        recv_byte(8'hB6, 1'b1, "R9 spiked byte 0");
        recv_byte(8'h3D, 1'b0, "R9 spiked byte 1");
        stop_c();

        w(20);
        chk(exp_q.size() == 0, "R4 all expected writes seen", exp_q.size(), 32'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule